// File: doc/BRIEF.md
# Rotating Register File

This block is a general register file for software-pipelined loops. Its entries are split into two regions. The lower region is static: a logical register number there selects the same physical entry every time. The upper region rotates. A logical number in that region is renamed through a rotation base. The base moves down by one each time the loop branches back. As a result, every iteration of a pipelined loop writes a fresh physical entry under the same logical name, and earlier iterations' values are still reachable under neighbouring names.

The block has two combinational read ports and one write port. A rotate strobe is raised on loop-back, and a clear input returns the base to zero before a new loop starts. Within the rotating region, logical slot `j` is the logical number minus the static count. Physical slot `p` is the physical entry minus the same count. The default sizes are 32 static and 96 rotating entries of 32 bits each.

Top module: `rot_regfile`

## Requirements
- R1: A logical index below N_STATIC (32) reads and writes physical entry equal to that index, whatever the base.
- R2: A logical index N_STATIC+j reaches physical entry N_STATIC+((j + base) mod N_ROT), with N_ROT = 96.
- R3: Each cycle with `rot_step` high and `base_clr` low moves the base down by one, from 0 it wraps to N_ROT-1, and with both low the base holds.
- R4: `base_clr` sets the base to zero on the next edge and takes priority over a simultaneous `rot_step`.
- R5: A value written to logical N_STATIC+k is read as logical N_STATIC+k+1 after one rotation; the value written to the last logical index (127) is read as logical N_STATIC (32).
- R6: A write in the same cycle as a rotate is addressed with the base in force before that rotation.
- R7: Both read ports are combinational, and a write in the same cycle to the same physical entry is returned on a read port in place of the stored value.
- R8: Synchronous reset clears every entry to zero and sets the base to zero.
- R9: With base 10, rotating slot 13 reaches physical slot 23; after one rotation (base 9) it reaches slot 22, and after another (base 8) slot 21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rot_step | input | 1 | Loop-back strobe, moves the base down by one |
| base_clr | input | 1 | Sets the base to zero |
| wr_en | input | 1 | Write enable |
| wr_idx | input | IDX_W (7) | Logical write register |
| wr_data | input | DATA_W (32) | Write data |
| rd0_idx | input | IDX_W (7) | Logical register for read port 0 |
| rd0_data | output | DATA_W (32) | Read port 0 data, combinational |
| rd1_idx | input | IDX_W (7) | Logical register for read port 1 |
| rd1_data | output | DATA_W (32) | Read port 1 data, combinational |

## Verification
A base that is off by one shows up on the first read of a rotating register after the faulty edge. The value comes back under the wrong logical neighbour, or as zero. A wrong wrap shows only when slot arithmetic crosses the top of the region, so the vectors deliberately write the last logical register and read it back at the bottom. Missing forwarding or a write that uses the post-rotation base appears in the same cycle, or one cycle later, as stale or misplaced data. A clear that loses to a rotate is seen as soon as data written at base zero is read again.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

  localparam int NUM_RD = 2;

  // Map a logical index to a physical entry under the given base.
  function automatic int rot_map(int idx, int base, int n_static, int n_rot);
    int slot;
    if (idx < n_static) begin
      return idx;
    end
    slot = idx - n_static + base;
    if (slot >= n_rot) begin
      slot = slot - n_rot;
    end
    return n_static + slot;
  endfunction

endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl #(
  parameter int N_ROT  = 96,
  parameter int BASE_W = $clog2(N_ROT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rot_step,
  input  logic              base_clr,
  output logic [BASE_W-1:0] base_q
);

  localparam logic [BASE_W-1:0] TOP = BASE_W'(N_ROT - 1);

  logic [BASE_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (base_clr) begin
      base_d = '0;
    end else if (rot_step) begin
      base_d = (base_q == '0) ? TOP : base_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else begin
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/rrf_rename.sv
module rrf_rename #(
  parameter int N_STATIC = 32,
  parameter int N_ROT    = 96,
  parameter int IDX_W    = $clog2(N_STATIC + N_ROT),
  parameter int BASE_W   = $clog2(N_ROT)
) (
  input  logic [IDX_W-1:0]  log_idx,
  input  logic [BASE_W-1:0] base,
  output logic [IDX_W-1:0]  phys_idx
);

  always_comb begin
    phys_idx = IDX_W'(rrf_pkg::rot_map(int'(log_idx), int'(base), N_STATIC, N_ROT));
  end

endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int NRD    = 2,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_phys,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_phys,
  output logic [NRD-1:0][DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '0;
      end
    end else if (wr_en) begin
      mem[wr_phys] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (wr_en && (wr_phys == rd_phys[p])) begin
        rd_data[p] = wr_data;
      end else begin
        rd_data[p] = mem[rd_phys[p]];
      end
    end
  end

endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
  parameter int DATA_W   = 32,
  parameter int N_STATIC = 32,
  parameter int N_ROT    = 96,
  parameter int IDX_W    = $clog2(N_STATIC + N_ROT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rot_step,
  input  logic              base_clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd1_data
);

  localparam int DEPTH  = N_STATIC + N_ROT;
  localparam int BASE_W = $clog2(N_ROT);
  localparam int NRD    = rrf_pkg::NUM_RD;

  logic [BASE_W-1:0]            base_q;
  logic [IDX_W-1:0]             wr_phys;
  logic [NRD-1:0][IDX_W-1:0]    rd_log;
  logic [NRD-1:0][IDX_W-1:0]    rd_phys;
  logic [NRD-1:0][DATA_W-1:0]   rd_data;

  assign rd_log[0] = rd0_idx;
  assign rd_log[1] = rd1_idx;

  rrf_base_ctrl #(.N_ROT(N_ROT), .BASE_W(BASE_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .rot_step (rot_step),
    .base_clr (base_clr),
    .base_q   (base_q)
  );

  rrf_rename #(.N_STATIC(N_STATIC), .N_ROT(N_ROT), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_wr_map (
    .log_idx  (wr_idx),
    .base     (base_q),
    .phys_idx (wr_phys)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd_map
    rrf_rename #(.N_STATIC(N_STATIC), .N_ROT(N_ROT), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_rd_map (
      .log_idx  (rd_log[p]),
      .base     (base_q),
      .phys_idx (rd_phys[p])
    );
  end

  rrf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NRD(NRD), .IDX_W(IDX_W)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_phys (wr_phys),
    .wr_data (wr_data),
    .rd_phys (rd_phys),
    .rd_data (rd_data)
  );

  assign rd0_data = rd_data[0];
  assign rd1_data = rd_data[1];

endmodule

// File: rtl/rot_regfile_checker.sv
module rot_regfile_checker #(
  parameter int DATA_W   = 32,
  parameter int N_STATIC = 32,
  parameter int N_ROT    = 96,
  parameter int IDX_W    = 7,
  parameter int BASE_W   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              rot_step,
  input logic              base_clr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  wr_phys,
  input logic [IDX_W-1:0]  rd0_idx,
  input logic [IDX_W-1:0]  rd0_phys,
  input logic [DATA_W-1:0] rd0_data,
  input logic [BASE_W-1:0] base
);

  AST_BASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(base) < N_ROT); // R3

  AST_BASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    rot_step && !base_clr && (base == '0) |=> base == BASE_W'(N_ROT - 1)); // R3

  AST_BASE_DEC: assert property (@(posedge clk) disable iff (rst)
    rot_step && !base_clr && (base != '0) |=> base == BASE_W'($past(base) - 1'b1)); // R3

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rot_step && !base_clr |=> $stable(base)); // R3

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    base_clr |=> base == '0); // R4

  AST_RESET_BASE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> base == '0); // R8

  AST_STATIC_MAP: assert property (@(posedge clk) disable iff (rst)
    int'(rd0_idx) < N_STATIC |-> rd0_phys == rd0_idx); // R1

  AST_FORWARD: assert property (@(posedge clk) disable iff (rst)
    wr_en && (wr_phys == rd0_phys) |-> rd0_data == wr_data); // R7

endmodule

bind rot_regfile rot_regfile_checker #(
  .DATA_W(DATA_W), .N_STATIC(N_STATIC), .N_ROT(N_ROT), .IDX_W(IDX_W), .BASE_W(BASE_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rot_step (rot_step),
  .base_clr (base_clr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .wr_phys  (wr_phys),
  .rd0_idx  (rd0_idx),
  .rd0_phys (rd_phys[0]),
  .rd0_data (rd0_data),
  .base     (base_q)
);

// File: tb/rot_regfile_test.sv
module rot_regfile_test;

  localparam int DATA_W = 32;
  localparam int IDX_W  = 7;

  typedef struct packed {
    logic              wr;
    logic              rot;
    logic [IDX_W-1:0]  widx;
    logic [DATA_W-1:0] wdata;
    logic [IDX_W-1:0]  ridx;
    logic [DATA_W-1:0] exp;
    logic [7:0]        req;
  } vec_t;

  // Starts at base 0 after reset; comments give the base in force for each row.
  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b0, 7'd5,   32'h11, 7'd5,   32'h11, 8'd7}, // R7 base 0, forward
    '{1'b1, 1'b0, 7'd40,  32'h22, 7'd5,   32'h11, 8'd1}, // R1 base 0
    '{1'b0, 1'b1, 7'd0,   32'h0,  7'd40,  32'h22, 8'd2}, // R2 base 0, then rotate
    '{1'b0, 1'b0, 7'd0,   32'h0,  7'd41,  32'h22, 8'd5}, // R5 base 95
    '{1'b0, 1'b0, 7'd0,   32'h0,  7'd5,   32'h11, 8'd1}, // R1 base 95
    '{1'b1, 1'b1, 7'd50,  32'h33, 7'd50,  32'h33, 8'd7}, // R7 base 95, write+rotate
    '{1'b0, 1'b0, 7'd0,   32'h0,  7'd51,  32'h33, 8'd6}, // R6 base 94
    '{1'b1, 1'b1, 7'd127, 32'h44, 7'd127, 32'h44, 8'd7}, // R7 base 94, last index
    '{1'b0, 1'b0, 7'd0,   32'h0,  7'd32,  32'h44, 8'd5}, // R5 base 93, wrap
    '{1'b0, 1'b0, 7'd0,   32'h0,  7'd127, 32'h0,  8'd2}  // R2 base 93, unwritten
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rot_step = 1'b0;
  logic              base_clr = 1'b0;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [IDX_W-1:0]  rd0_idx = '0;
  logic [IDX_W-1:0]  rd1_idx = '0;
  logic [DATA_W-1:0] rd0_data;
  logic [DATA_W-1:0] rd1_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  rot_regfile uut (
    .clk      (clk),
    .rst      (rst),
    .rot_step (rot_step),
    .base_clr (base_clr),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd0_idx  (rd0_idx),
    .rd0_data (rd0_data),
    .rd1_idx  (rd1_idx),
    .rd1_data (rd1_data)
  );

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs after a falling edge; reads settle 1 ns later.
  task automatic drive(logic w, logic r, logic c, logic [IDX_W-1:0] wi,
                       logic [DATA_W-1:0] wd, logic [IDX_W-1:0] ri0, logic [IDX_W-1:0] ri1);
    @(negedge clk);
    wr_en = w; rot_step = r; base_clr = c;
    wr_idx = wi; wr_data = wd; rd0_idx = ri0; rd1_idx = ri1;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R8: entries read zero straight after reset
    drive(1'b0, 1'b0, 1'b0, '0, '0, 7'd5, 7'd100);
    check("R8 static entry after reset", rd0_data, 32'h0);
    check("R8 rotating entry after reset", rd1_data, 32'h0);

    foreach (VECS[i]) begin
      drive(VECS[i].wr, VECS[i].rot, 1'b0, VECS[i].widx, VECS[i].wdata,
            VECS[i].ridx, VECS[i].ridx);
      check($sformatf("R%0d vector %0d port0", VECS[i].req, i), rd0_data, VECS[i].exp);
      check($sformatf("R%0d vector %0d port1", VECS[i].req, i), rd1_data, VECS[i].exp);
    end

    // R4: clear together with rotate; base returns to 0 where logical 40 was written
    drive(1'b0, 1'b1, 1'b1, '0, '0, '0, '0);
    drive(1'b0, 1'b0, 1'b0, '0, '0, 7'd40, 7'd41);
    check("R4 clear beats rotate, logical 40", rd0_data, 32'h22);
    check("R4 clear beats rotate, logical 41", rd1_data, 32'h0);

    // R9: slots 23,22,21 written at base 0, rotate 86 times to base 10
    drive(1'b1, 1'b0, 1'b0, 7'd55, 32'hA23, '0, '0);
    drive(1'b1, 1'b0, 1'b0, 7'd54, 32'hA22, '0, '0);
    drive(1'b1, 1'b0, 1'b0, 7'd53, 32'hA21, '0, '0);
    for (int k = 0; k < 86; k++) begin
      drive(1'b0, 1'b1, 1'b0, '0, '0, '0, '0);
    end
    drive(1'b0, 1'b1, 1'b0, '0, '0, 7'd45, 7'd45);
    check("R9 base 10 slot 13", rd0_data, 32'hA23);
    drive(1'b0, 1'b1, 1'b0, '0, '0, 7'd45, 7'd45);
    check("R9 base 9 slot 13", rd1_data, 32'hA22);
    drive(1'b0, 1'b0, 1'b0, '0, '0, 7'd45, 7'd5);
    check("R9 base 8 slot 13", rd0_data, 32'hA21);
    check("R1 static unaffected at base 8", rd1_data, 32'h11);

    // R8: mid-run reset clears previously written entries
    @(negedge clk);
    rst = 1'b1;
    wr_en = 1'b0; rot_step = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0, '0, '0, 7'd5, 7'd45);
    check("R8 static cleared", rd0_data, 32'h0);
    check("R8 rotating cleared", rd1_data, 32'h0);
    idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule